// File: doc/BRIEF.md
# Multistage Cascaded Watchdog

This block supervises software through a chain of timer stages that run one after another. Once enabled, the first stage counts down its own programmed interval. Software keeps the system healthy by pulsing the kick input while the first stage is active, which restarts that stage's interval. If the first stage runs out, the block raises a one-cycle corrective-action pulse for it and the second stage begins timing. Each further stage does the same in turn. The final stage's pulse is the system reset request, and the chain stops there.

All stages share one down counter. A small sequencer tracks which stage is running, and it reloads the counter with the next stage's interval at the edge where the current stage expires. Earlier stages can drive gentler recovery steps, such as an interrupt or a log capture, before the last stage forces a restart. After the final pulse the block parks in a terminal state. It leaves that state only through reset, or by deasserting enable and then asserting it again.

Top module: `wdt_cascade`

## Requirements
- R1: While reset is high, and afterwards for as long as enable stays low, `action_o` is all zero and `stage_o` is 0.
- R2: If enable is first seen high at clock edge S, stage 0 is loaded from field 0 of `interval_i`. With an effective interval N0, `action_o[0]` is high during the cycle that follows edge S+N0.
- R3: Each action bit is high for exactly one cycle per timeout, and at most one action bit is high in any cycle.
- R4: When a stage k other than the last times out, `stage_o` becomes k+1 at that same edge. Stage k+1 then times out N(k+1) edges later, where N(k+1) is its effective interval.
- R5: A kick sampled at edge K while stage 0 is running restarts stage 0, so it times out at edge K+N0 and `stage_o` stays 0. A kick sampled on the very edge that stage 0 would expire takes priority, and no action fires.
- R6: A kick has no effect while any stage other than stage 0 is running, or while the block is in the terminal state.
- R7: The last stage's timeout raises `action_o[NUM_STAGES-1]`, which is the system reset request, and starts no further stage. While enable stays high, `stage_o` then holds NUM_STAGES-1 and no further pulses appear.
- R8: An interval field of value 0 behaves as an interval of 1 cycle. Any other value V behaves as V cycles.
- R9: Enable sampled low at an edge returns the block to idle. The next cycle shows `stage_o` = 0 and no action, even if a stage would have expired at that edge. A later enable starts again from stage 0.
- R10: `stage_o` is the binary index of the running stage. Bit i of `action_o` belongs to stage i. Stage i's interval sits in `interval_i[i*CNT_W +: CNT_W]` and is read at the edge where stage i is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Runs the watchdog while high; idles it while low |
| kick_i | input | 1 | Restart request, honoured only during stage 0 |
| interval_i | input | NUM_STAGES*CNT_W | Per-stage interval fields, stage i at bits i*CNT_W |
| action_o | output | NUM_STAGES | One-cycle corrective-action pulses, one bit per stage |
| stage_o | output | $clog2(NUM_STAGES) | Index of the running stage |

## Verification
Every result is counted in clock edges from the edge that samples the cause. The start edge loads the counter. A stage with effective interval N then pulses in the cycle after its Nth following edge, and `stage_o` advances at that same edge. A kick or a disable shows its effect one edge after it is sampled. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge, so each sample sees exactly the edges it predicted. The expected pulse edges come from running sums of the effective intervals, worked out in the bench from R2, R4, R5 and R8.

// File: rtl/wdt_cascade_pkg.sv
package wdt_cascade_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RUN  = 2'd1,
        WS_DONE = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic fire;
        logic run;
    } seq_flags_t;

    // A programmed value of 0 counts as one cycle; the counter holds cycles left minus one.
    function automatic logic [31:0] reload_of(input logic [31:0] ticks);
        return (ticks == 32'd0) ? 32'd0 : ticks - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_cascade_ivsel.sv
module wdt_cascade_ivsel
    import wdt_cascade_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    parameter int CNT_W      = 16,
    localparam int SIDX_W    = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic [NUM_STAGES*CNT_W-1:0] interval_i,
    input  logic [SIDX_W-1:0]           sel_i,
    output logic [CNT_W-1:0]            reload_o
);
    localparam logic [SIDX_W-1:0] LAST = SIDX_W'(NUM_STAGES - 1);

    logic [CNT_W-1:0]  field [NUM_STAGES];
    logic [SIDX_W-1:0] sel_c;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_field
        assign field[g] = interval_i[g*CNT_W +: CNT_W];
    end

    always_comb begin
        sel_c    = (sel_i > LAST) ? LAST : sel_i;
        reload_o = CNT_W'(reload_of(32'(field[sel_c])));
    end

endmodule

// File: rtl/wdt_cascade_counter.sv
module wdt_cascade_counter
    import wdt_cascade_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  cnt_op_e          op_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            unique case (op_i)
                CNT_LOAD: cnt_q <= reload_i;
                CNT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o   = cnt_q;
    assign expired_o = (cnt_q == '0);

    // R8: the sequencer never asks the shared counter to step below zero
    a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == CNT_DEC) |-> (cnt_q != '0));

endmodule

// File: rtl/wdt_cascade_seq.sv
module wdt_cascade_seq
    import wdt_cascade_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    localparam int SIDX_W    = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              enable_i,
    input  logic              kick_i,
    input  logic              expired_i,
    output cnt_op_e           op_o,
    output logic [SIDX_W-1:0] sel_o,
    output logic [SIDX_W-1:0] stage_o,
    output seq_flags_t        flags_o
);
    localparam logic [SIDX_W-1:0] LAST = SIDX_W'(NUM_STAGES - 1);

    wdt_state_e        state_q, state_d;
    logic [SIDX_W-1:0] stage_q, stage_d;

    always_comb begin
        state_d       = state_q;
        stage_d       = stage_q;
        op_o          = CNT_HOLD;
        sel_o         = '0;
        flags_o.fire  = 1'b0;
        flags_o.run   = (state_q == WS_RUN);
        unique case (state_q)
            WS_IDLE: begin
                if (enable_i) begin
                    state_d = WS_RUN;
                    stage_d = '0;
                    op_o    = CNT_LOAD;
                end
            end
            WS_RUN: begin
                if (!enable_i) begin
                    state_d = WS_IDLE;
                    stage_d = '0;
                end else if (kick_i && stage_q == '0) begin
                    op_o = CNT_LOAD;
                end else if (expired_i) begin
                    flags_o.fire = 1'b1;
                    if (stage_q == LAST) begin
                        state_d = WS_DONE;
                    end else begin
                        stage_d = stage_q + SIDX_W'(1);
                        sel_o   = stage_q + SIDX_W'(1);
                        op_o    = CNT_LOAD;
                    end
                end else begin
                    op_o = CNT_DEC;
                end
            end
            default: begin
                if (!enable_i) begin
                    state_d = WS_IDLE;
                    stage_d = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= WS_IDLE;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    assign stage_o = stage_q;

    // R4: an expiring non-final stage hands over to the following one
    a_r4_stage_advance: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WS_RUN && enable_i && expired_i && !(kick_i && stage_q == '0)
         && stage_q != LAST) |=> (stage_q == $past(stage_q) + SIDX_W'(1)));

    // R6: kicks do not move a later stage
    a_r6_late_kick: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WS_RUN && enable_i && kick_i && stage_q != '0 && !expired_i)
        |=> (stage_q == $past(stage_q) && state_q == WS_RUN));

    // R7: the terminal state is held while enable stays high
    a_r7_terminal_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WS_DONE && enable_i) |=> (state_q == WS_DONE && stage_q == LAST));

endmodule

// File: rtl/wdt_cascade_action.sv
module wdt_cascade_action
    import wdt_cascade_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    localparam int SIDX_W    = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  seq_flags_t            flags_i,
    input  logic [SIDX_W-1:0]     stage_i,
    output logic [NUM_STAGES-1:0] action_o
);
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_act
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                action_o[g] <= 1'b0;
            end else begin
                action_o[g] <= flags_i.fire && (stage_i == SIDX_W'(g));
            end
        end
    end

    // R3: never more than one corrective action at a time
    a_r3_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(action_o));

    // R3: a pulse never repeats on the following cycle
    a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        (action_o != '0) |=> (action_o != $past(action_o)));

endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
    import wdt_cascade_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    parameter int CNT_W      = 16,
    localparam int SIDX_W    = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        enable_i,
    input  logic                        kick_i,
    input  logic [NUM_STAGES*CNT_W-1:0] interval_i,
    output logic [NUM_STAGES-1:0]       action_o,
    output logic [SIDX_W-1:0]           stage_o
);
    cnt_op_e           op_w;
    logic [SIDX_W-1:0] sel_w;
    logic [SIDX_W-1:0] stage_w;
    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  count_w;
    logic              expired_w;
    seq_flags_t        flags_w;

    wdt_cascade_seq #(.NUM_STAGES(NUM_STAGES)) u_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .enable_i  (enable_i),
        .kick_i    (kick_i),
        .expired_i (expired_w),
        .op_o      (op_w),
        .sel_o     (sel_w),
        .stage_o   (stage_w),
        .flags_o   (flags_w)
    );

    wdt_cascade_ivsel #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) u_ivsel (
        .interval_i (interval_i),
        .sel_i      (sel_w),
        .reload_o   (reload_w)
    );

    wdt_cascade_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .op_i      (op_w),
        .reload_i  (reload_w),
        .count_o   (count_w),
        .expired_o (expired_w)
    );

    wdt_cascade_action #(.NUM_STAGES(NUM_STAGES)) u_act (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .flags_i  (flags_w),
        .stage_i  (stage_w),
        .action_o (action_o)
    );

    assign stage_o = stage_w;

    // R5: an accepted kick reloads the shared counter and keeps stage 0
    a_r5_kick_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags_w.run && enable_i && kick_i && stage_w == '0)
        |=> (stage_o == '0 && action_o == '0 && count_w == $past(reload_w)));

    // R9: a low enable idles the block at the next edge
    a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> (action_o == '0 && stage_o == '0));

endmodule

// File: tb/test_wdt_cascade.sv
module test_wdt_cascade;
    localparam int NS = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          kick = 1'b0;
    logic [NS*CW-1:0] intervals = '0;
    logic [NS-1:0] action;
    logic [1:0]    stage;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wdt_cascade #(.NUM_STAGES(NS), .CNT_W(CW)) i_wdt_cascade (
        .clk_i      (clk),
        .rst_i      (rst),
        .enable_i   (enable),
        .kick_i     (kick),
        .interval_i (intervals),
        .action_o   (action),
        .stage_o    (stage)
    );

    // stage intervals per scenario: stage 0, stage 1, stage 2
    localparam int unsigned VEC [5][3] = '{
        '{3, 4, 2},
        '{1, 1, 1},
        '{0, 0, 0},
        '{6, 2, 5},
        '{2, 0, 3}
    };

    function automatic int eff(input int unsigned v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; enable = 1'b0; kick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_iv(input int a, input int b, input int c);
        intervals = {CW'(c), CW'(b), CW'(a)};
    endtask

    // raise enable; the next edge is the start edge
    task automatic start();
        enable = 1'b1;
        @(negedge clk);
        chk(stage == 2'd0, "R2 start stage", stage, 0);
        chk(action == '0, "R2 start action", action, 0);
    endtask

    // walk n edges after the start edge; pulses due at edges e0, e1, e2
    task automatic watch(input int n, input int e0, input int e1, input int e2,
                         input int kick_t, input string req);
        for (int t = 1; t <= n; t++) begin
            int exp_a;
            int exp_s;
            kick = (t == kick_t);
            @(negedge clk);
            exp_a = (t == e0) ? 1 : (t == e1) ? 2 : (t == e2) ? 4 : 0;
            exp_s = (t < e0) ? 0 : (t < e1) ? 1 : 2;
            chk(action == NS'(exp_a), req, action, exp_a);
            chk(stage == 2'(exp_s), req, stage, exp_s);
        end
        kick = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : main
        // R1: reset and idle with enable low
        rst = 1'b1;
        @(negedge clk);
        chk(action == '0, "R1 in reset action", action, 0);
        chk(stage == 2'd0, "R1 in reset stage", stage, 0);
        rst = 1'b0;
        set_iv(1, 1, 1);
        repeat (6) begin
            kick = 1'b1;
            @(negedge clk);
            chk(action == '0, "R1 idle action", action, 0);
            chk(stage == 2'd0, "R1 idle stage", stage, 0);
        end
        kick = 1'b0;

        // R2 R4 R7 R8 R10: table of interval sets
        for (int v = 0; v < 5; v++) begin
            int e0;
            int e1;
            int e2;
            do_reset();
            set_iv(VEC[v][0], VEC[v][1], VEC[v][2]);
            e0 = eff(VEC[v][0]);
            e1 = e0 + eff(VEC[v][1]);
            e2 = e1 + eff(VEC[v][2]);
            start();
            watch(e2 + 5, e0, e1, e2, 0, "R2/R4/R7/R8/R10 vector");
        end

        // R5: kick during stage 0 moves its timeout to kick edge + interval
        do_reset();
        set_iv(5, 3, 2);
        start();
        watch(16, 8, 11, 13, 3, "R5 kick reload");

        // R5: kick on the would-be expiry edge wins
        do_reset();
        set_iv(5, 3, 2);
        start();
        watch(18, 10, 13, 15, 5, "R5 kick at expiry");

        // R6: kick during stage 1 is ignored
        do_reset();
        set_iv(3, 6, 2);
        start();
        watch(14, 3, 9, 11, 5, "R6 late kick");

        // R6 R7: terminal state ignores kicks and stays put
        repeat (8) begin
            kick = 1'b1;
            @(negedge clk);
            chk(action == '0, "R7 terminal action", action, 0);
            chk(stage == 2'd2, "R7 terminal stage", stage, 2);
        end
        kick = 1'b0;

        // R9: leave terminal via disable then restart
        enable = 1'b0;
        @(negedge clk);
        chk(stage == 2'd0, "R9 terminal disable", stage, 0);
        start();
        watch(14, 3, 9, 11, 0, "R9 restart after terminal");

        // R9: disable mid-stage suppresses the pending pulse
        do_reset();
        set_iv(4, 4, 4);
        start();
        watch(2, 4, 8, 12, 0, "R9 before disable");
        enable = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(action == '0, "R9 disabled action", action, 0);
            chk(stage == 2'd0, "R9 disabled stage", stage, 0);
        end
        start();
        watch(14, 4, 8, 12, 0, "R9 re-enable");

        // R9: disable on the expiry edge of stage 1
        do_reset();
        set_iv(2, 3, 2);
        start();
        watch(4, 2, 5, 7, 0, "R9 run-up");
        enable = 1'b0;
        @(negedge clk);
        chk(action == '0, "R9 disable at expiry action", action, 0);
        chk(stage == 2'd0, "R9 disable at expiry stage", stage, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule